// File: doc/BRIEF.md
# Fused multiply-add special-operand resolver

This block sits at the front of a double-precision fused multiply-add unit. It computes z + x·y, or z − x·y when the negate-product input is set. It receives the three raw operand words, the negate-product control and the current rounding mode. It sorts each operand into one of six classes:

- zero
- subnormal
- normal
- infinity
- quiet NaN
- signaling NaN

It then decides whether the final answer follows from the classes and signs alone. When it does, the block delivers the finished 64-bit result and the invalid-operation flag. When the operands call for real arithmetic, it raises `compute` so that the multiply, align and round datapath takes over.

Results are registered and appear one clock after the operands are presented. A synchronous active-high reset clears every output. The field widths are parameters, so the same logic can serve a narrower format. The defaults give the 64-bit layout: sign in bit 63, an 11-bit exponent in bits 62:52 and a 52-bit fraction in bits 51:0.

Top module: `fma_special_resolve`

## Requirements
- R1: Classification uses the exponent field and the fraction field. Exponent zero gives zero (fraction zero) or subnormal (fraction nonzero). Exponent all ones gives infinity (fraction zero), quiet NaN (fraction bit 51 set) or signaling NaN (fraction nonzero, bit 51 clear). Any other exponent gives normal.
- R2: If any operand is a signaling NaN, the result is the first such operand in the order z, x, y, with fraction bit 51 forced to one, and invalid is raised.
- R3: If no operand is a signaling NaN, the first quiet NaN in the order z, x, y is returned bit for bit, and invalid stays low.
- R4: With no NaN present, infinity times zero (in either operand order) returns the default NaN 64'h7FF8_0000_0000_0000 and raises invalid.
- R5: The effective product sign is sign(x) xor sign(y), inverted when negate-product is 1. An infinite product with an infinite z whose sign differs from that effective sign returns the default NaN and raises invalid.
- R6: Any other infinite product returns infinity (exponent all ones, fraction zero) carrying the effective product sign.
- R7: A finite product (zero or nonzero) with an infinite z returns z.
- R8: A zero product with a zero z returns z when the sign of z equals the effective product sign. Otherwise it returns a zero whose sign bit is 1 only when the rounding mode is 2'b11 (toward minus infinity).
- R9: A zero product with a nonzero finite z (normal or subnormal) returns z unchanged.
- R10: `compute` is 1 exactly when x and y are both finite and nonzero and z is finite. In that case the result and invalid are 0 and `resolved` is 0. In every other case `resolved` is 1 and `compute` is 0.
- R11: All outputs change only at a clock edge, one cycle after the inputs. While reset is high they are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_z | input | 64 | Addend operand word |
| op_x | input | 64 | First multiplicand word |
| op_y | input | 64 | Second multiplicand word |
| neg_prod | input | 1 | 1 selects z − x·y, 0 selects z + x·y |
| rnd_mode | input | 2 | Rounding mode; 2'b11 means toward minus infinity |
| res | output | 64 | Resolved result word (0 when compute is set) |
| inv_op | output | 1 | Invalid-operation flag |
| resolved | output | 1 | Result fully determined by special cases |
| compute | output | 1 | Operands must go through the arithmetic datapath |

## Verification
The assertions assume that the operand words are fully driven (never X) in every cycle outside reset, because the next-state decisions are checked combinationally at each edge. They also assume that the rounding mode is always one of the four two-bit codes. The stimulus holds all inputs at defined values from time zero and changes them only between edges. It builds every operand from an explicit class and sign, so every combination of the six classes and two signs on all three operands is reached under both product modes and all four rounding modes.

// File: rtl/fma_res_pkg.sv
package fma_res_pkg;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } opclass_t;

  function automatic logic is_fin_nz(input opclass_t c);
    return (c == CL_SUB) || (c == CL_NORM);
  endfunction

  function automatic logic is_fin(input opclass_t c);
    return (c == CL_ZERO) || (c == CL_SUB) || (c == CL_NORM);
  endfunction

endpackage

// File: rtl/fma_opclass.sv
module fma_opclass
  import fma_res_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output opclass_t              cls,
  output logic                  sgn
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  assign sgn = word[WORD_W-1];
  assign ex  = word[WORD_W-2:FRAC_W];
  assign fr  = word[FRAC_W-1:0];

  always_comb begin
    if (ex == '0)
      cls = (fr == '0) ? CL_ZERO : CL_SUB;
    else if (&ex) begin
      if (fr == '0)           cls = CL_INF;
      else if (fr[FRAC_W-1])  cls = CL_QNAN;
      else                    cls = CL_SNAN;
    end else
      cls = CL_NORM;
  end

endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick #(
  parameter int N_OPS  = 3,
  parameter int WORD_W = 64,
  parameter int FRAC_W = 52
) (
  input  logic [N_OPS-1:0][WORD_W-1:0] words,
  input  logic [N_OPS-1:0]             sig_nan,
  input  logic [N_OPS-1:0]             q_nan,
  output logic                         hit,
  output logic                         hit_sig,
  output logic [WORD_W-1:0]            pick
);
  localparam logic [WORD_W-1:0] QBIT = WORD_W'(1) << (FRAC_W - 1);

  logic [WORD_W-1:0] sig_word;
  logic [WORD_W-1:0] q_word;

  // Scan from the lowest priority upward so index 0 wins.
  always_comb begin
    sig_word = '0;
    q_word   = '0;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (sig_nan[i]) sig_word = words[i] | QBIT;
      if (q_nan[i])   q_word   = words[i];
    end
  end

  assign hit_sig = |sig_nan;
  assign hit     = hit_sig | (|q_nan);
  assign pick    = hit_sig ? sig_word : q_word;

endmodule

// File: rtl/fma_special_core.sv
module fma_special_core
  import fma_res_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int RM_W    = 2,
  parameter logic [RM_W-1:0] RM_DOWN = 2'b11
) (
  input  opclass_t                 cls_z,
  input  opclass_t                 cls_x,
  input  opclass_t                 cls_y,
  input  logic                     sz,
  input  logic                     sx,
  input  logic                     sy,
  input  logic [EXP_W+FRAC_W:0]    op_z,
  input  logic                     nan_hit,
  input  logic                     nan_sig,
  input  logic [EXP_W+FRAC_W:0]    nan_word,
  input  logic                     neg_prod,
  input  logic [RM_W-1:0]          rnd_mode,
  output logic [EXP_W+FRAC_W:0]    nxt_res,
  output logic                     nxt_inv,
  output logic                     nxt_cmp
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [WORD_W-1:0] DNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic p_sgn, inf_zero, p_inf, p_zero;

  assign p_sgn    = sx ^ sy ^ neg_prod;
  assign inf_zero = (cls_x == CL_INF && cls_y == CL_ZERO) ||
                    (cls_x == CL_ZERO && cls_y == CL_INF);
  assign p_inf    = (cls_x == CL_INF) || (cls_y == CL_INF);
  assign p_zero   = (cls_x == CL_ZERO) || (cls_y == CL_ZERO);

  always_comb begin
    nxt_res = '0;
    nxt_inv = 1'b0;
    nxt_cmp = 1'b0;
    if (nan_hit) begin
      nxt_res = nan_word;
      nxt_inv = nan_sig;
    end else if (inf_zero) begin
      nxt_res = DNAN;
      nxt_inv = 1'b1;
    end else if (p_inf) begin
      if (cls_z == CL_INF && sz != p_sgn) begin
        nxt_res = DNAN;
        nxt_inv = 1'b1;
      end else
        nxt_res = {p_sgn, INF_MAG};
    end else if (cls_z == CL_INF) begin
      nxt_res = op_z;
    end else if (p_zero) begin
      if (cls_z == CL_ZERO && sz != p_sgn)
        nxt_res = {rnd_mode == RM_DOWN, {(WORD_W-1){1'b0}}};
      else
        nxt_res = op_z;
    end else
      nxt_cmp = 1'b1;
  end

endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_res_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int RM_W    = 2,
  parameter logic [RM_W-1:0] RM_DOWN = 2'b11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [EXP_W+FRAC_W:0]      op_z,
  input  logic [EXP_W+FRAC_W:0]      op_x,
  input  logic [EXP_W+FRAC_W:0]      op_y,
  input  logic                       neg_prod,
  input  logic [RM_W-1:0]            rnd_mode,
  output logic [EXP_W+FRAC_W:0]      res,
  output logic                       inv_op,
  output logic                       resolved,
  output logic                       compute
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int N_OPS  = 3;
  localparam logic [WORD_W-1:0] DNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [N_OPS-1:0][WORD_W-1:0] ops;
  opclass_t                     cls [N_OPS];
  logic [N_OPS-1:0]             sgn;
  logic [N_OPS-1:0]             snan_v, qnan_v;

  assign ops[0] = op_z;
  assign ops[1] = op_x;
  assign ops[2] = op_y;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fma_opclass #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (ops[g]),
      .cls  (cls[g]),
      .sgn  (sgn[g])
    );
    assign snan_v[g] = (cls[g] == CL_SNAN);
    assign qnan_v[g] = (cls[g] == CL_QNAN);
  end

  logic              nan_hit, nan_sig;
  logic [WORD_W-1:0] nan_word;

  fma_nan_pick #(.N_OPS(N_OPS), .WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_nan (
    .words   (ops),
    .sig_nan (snan_v),
    .q_nan   (qnan_v),
    .hit     (nan_hit),
    .hit_sig (nan_sig),
    .pick    (nan_word)
  );

  logic [WORD_W-1:0] nxt_res;
  logic              nxt_inv, nxt_cmp;

  fma_special_core #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .RM_W(RM_W), .RM_DOWN(RM_DOWN)
  ) u_core (
    .cls_z    (cls[0]),
    .cls_x    (cls[1]),
    .cls_y    (cls[2]),
    .sz       (sgn[0]),
    .sx       (sgn[1]),
    .sy       (sgn[2]),
    .op_z     (op_z),
    .nan_hit  (nan_hit),
    .nan_sig  (nan_sig),
    .nan_word (nan_word),
    .neg_prod (neg_prod),
    .rnd_mode (rnd_mode),
    .nxt_res  (nxt_res),
    .nxt_inv  (nxt_inv),
    .nxt_cmp  (nxt_cmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res      <= '0;
      inv_op   <= 1'b0;
      resolved <= 1'b0;
      compute  <= 1'b0;
    end else begin
      res      <= nxt_res;
      inv_op   <= nxt_inv;
      resolved <= !nxt_cmp;
      compute  <= nxt_cmp;
    end
  end

  // Signaling NaN anywhere: quiet NaN out, invalid raised (R2)
  assert_snan_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (|snan_v) |-> (nxt_inv && nxt_res[FRAC_W-1] && (&nxt_res[WORD_W-2:FRAC_W])));

  // Quiet NaN in z with no signaling NaN passes z through (R3)
  assert_qnan_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (qnan_v[0] && !(|snan_v)) |-> (nxt_res == op_z && !nxt_inv));

  // Infinity times zero without NaN gives default NaN (R4)
  assert_inf_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!(|snan_v) && !(|qnan_v) && cls[1] == CL_INF && cls[2] == CL_ZERO)
      |-> (nxt_res == DNAN && nxt_inv));

  // Finite nonzero product with infinite z returns z (R7)
  assert_inf_addend_R7: assert property (@(posedge clk) disable iff (rst)
    (cls[0] == CL_INF && is_fin_nz(cls[1]) && is_fin_nz(cls[2]))
      |-> (nxt_res == op_z && !nxt_inv && !nxt_cmp));

  // Compute only for finite nonzero factors and finite addend (R10)
  assert_compute_cls_R10: assert property (@(posedge clk) disable iff (rst)
    nxt_cmp |-> (is_fin_nz(cls[1]) && is_fin_nz(cls[2]) && is_fin(cls[0])));

  // Registered outputs: handoff and resolution never together (R10)
  assert_excl_out_R10: assert property (@(posedge clk) disable iff (rst)
    !(compute && resolved));

  // Invalid flag always accompanies a quiet NaN result (R5)
  assert_inv_is_nan_R5: assert property (@(posedge clk) disable iff (rst)
    inv_op |-> (res[FRAC_W-1] && (&res[WORD_W-2:FRAC_W])));

endmodule

// File: tb/test_fma_special_resolve.sv
`timescale 1ns/1ps
module test_fma_special_resolve;

  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] QBIT = 64'h0008_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_z = '0, op_x = '0, op_y = '0;
  logic        neg_prod = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic [63:0] res;
  logic        inv_op, resolved, compute;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fma_special_resolve i_fma_special_resolve (
    .clk(clk), .rst(rst), .op_z(op_z), .op_x(op_x), .op_y(op_y),
    .neg_prod(neg_prod), .rnd_mode(rnd_mode),
    .res(res), .inv_op(inv_op), .resolved(resolved), .compute(compute)
  );

  // class codes: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qNaN, 5 sNaN
  function automatic logic [63:0] mk(input int c, input bit s, input int v);
    logic [10:0] e;
    logic [51:0] f;
    case (c)
      0: begin e = '0; f = '0; end
      1: begin e = '0; f = 52'(v % 97 + 1) << (v % 40); end
      2: begin e = 11'(1 + (v * 13) % 2046); f = 52'(v) * 52'd7919; end
      3: begin e = '1; f = '0; end
      4: begin e = '1; f = {1'b1, 51'(v * 3 + 5)}; end
      default: begin e = '1; f = {1'b0, 51'(v % 500 + 1) << (v % 30)}; end
    endcase
    return {s, e, f};
  endfunction

  task automatic model(input int cz, cx, cy, input bit sz, sx, sy, ng,
                       input logic [1:0] rm, input logic [63:0] z, x, y,
                       output logic [63:0] r, output bit iv, cm,
                       output string tag);
    bit ps;
    ps = sx ^ sy ^ ng;
    r = '0; iv = 0; cm = 0;
    if (cz == 5)      begin r = z | QBIT; iv = 1; tag = "R2"; end
    else if (cx == 5) begin r = x | QBIT; iv = 1; tag = "R2"; end
    else if (cy == 5) begin r = y | QBIT; iv = 1; tag = "R2"; end
    else if (cz == 4) begin r = z; tag = "R3"; end
    else if (cx == 4) begin r = x; tag = "R3"; end
    else if (cy == 4) begin r = y; tag = "R3"; end
    else if ((cx == 3 && cy == 0) || (cx == 0 && cy == 3)) begin
      r = DNAN; iv = 1; tag = "R4";
    end else if (cx == 3 || cy == 3) begin
      if (cz == 3 && sz != ps) begin r = DNAN; iv = 1; tag = "R5"; end
      else begin r = {ps, 11'h7FF, 52'd0}; tag = "R6"; end
    end else if (cz == 3) begin r = z; tag = "R7"; end
    else if (cx == 0 || cy == 0) begin
      if (cz == 0) begin
        tag = "R8";
        r = (sz == ps) ? z : {(rm == 2'b11), 63'd0};
      end else begin r = z; tag = "R9"; end
    end else begin cm = 1; tag = "R10"; end
  endtask

  task automatic check(input string tag, input logic [63:0] er,
                       input bit ei, ec, er_ok);
    n_chk++;
    if (res !== er || inv_op !== ei || compute !== ec || resolved !== er_ok) begin
      n_bad++;
      $display("FAIL %s: res=%h inv=%b cmp=%b rsv=%b expected res=%h inv=%b cmp=%b rsv=%b",
               tag, res, inv_op, compute, resolved, er, ei, ec, er_ok);
    end
  endtask

  task automatic apply_chk(input int cz, cx, cy, input bit sz, sx, sy, ng,
                           input logic [1:0] rm, input int v);
    logic [63:0] z, x, y, er;
    bit iv, cm;
    string tag;
    z = mk(cz, sz, v); x = mk(cx, sx, v + 1); y = mk(cy, sy, v + 2);
    op_z = z; op_x = x; op_y = y; neg_prod = ng; rnd_mode = rm;
    model(cz, cx, cy, sz, sx, sy, ng, rm, z, x, y, er, iv, cm, tag);
    @(posedge clk); #1;
    check(tag, er, iv, cm, !cm);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    v = 0;
    // R11: outputs cleared under reset
    op_z = 64'h7FF0_0000_0000_0001; op_x = DNAN;
    repeat (3) @(posedge clk);
    #1;
    check("R11", 64'd0, 0, 0, 0);
    rst = 1'b0;

    // R1: classification corners by raw encoding
    op_z = 64'h7FF0_0000_0000_0001; op_x = 64'h3FF0_0000_0000_0000;
    op_y = 64'h3FF0_0000_0000_0000; neg_prod = 0; rnd_mode = 0;
    @(posedge clk); #1;
    check("R1 snan", 64'h7FF8_0000_0000_0001, 1, 0, 1);
    op_z = 64'h8000_0000_0000_0001; op_x = 64'h0;
    @(posedge clk); #1;
    check("R1 subnormal", 64'h8000_0000_0000_0001, 0, 0, 1);
    op_z = 64'h0000_0000_0000_0000; op_x = 64'h0000_0000_0000_0003;
    op_y = 64'h0010_0000_0000_0000;
    @(posedge clk); #1;
    check("R1 finite", 64'd0, 0, 1, 0);

    // R2..R10: full sweep of classes, signs, modes
    for (int cz = 0; cz < 6; cz++)
      for (int cx = 0; cx < 6; cx++)
        for (int cy = 0; cy < 6; cy++)
          for (int s = 0; s < 8; s++)
            for (int ng = 0; ng < 2; ng++)
              for (int rm = 0; rm < 4; rm++) begin
                apply_chk(cz, cx, cy, s[2], s[1], s[0], ng[0], 2'(rm), v);
                v++;
              end

    // R11: reset mid-run clears outputs again
    op_z = DNAN; rst = 1'b1;
    @(posedge clk); #1;
    check("R11 mid", 64'd0, 0, 0, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule